// File: doc/BRIEF.md
# Ratio-Locked Clock Crossing Controller

This block sits in a fast clock domain and keeps a model of a slower clock that is locked to it by a fractional ratio. Both clocks are assumed to start together from a common reference, so their rising edges meet again at a fixed repeating interval. A phase accumulator in the fast domain tracks the slow clock's phase. The block predicts each coincidence of the two clocks' edges and raises a one-cycle aligned strobe a programmable number of fast cycles ahead of that point. This lead covers the fast-clock latency to the destination.

On every aligned strobe, one data word moves in each direction. A word bound for the slow side and a word bound for the fast side each wait in a one-word holding slot until the next strobe releases them. A word that arrives while its slot is still occupied sets a sticky overflow flag. The ratio and the lead are read only while the resynchronisation input is high. Releasing that input restarts the phase model at a coincidence point.

Top module: `ratio_xing_ctrl`

## Requirements
- R1: The ratio code and lead are captured only on cycles where `resync` is high. Changing `ratio_k` or `lead_sel` while running has no effect on any output.
- R2: Call the first cycle after `resync` falls n=0. `slow_edge` is high in cycle n exactly when (4·n mod k) < 4, where the ratio is k/4. It is low while `resync` is high.
- R3: Let P = k / gcd(k,4) and let L be the effective lead. `aligned` is high in cycle n exactly when (n+L) mod P = 0. It is low while `resync` is high.
- R4: A requested lead L ≥ P is reduced to P−1.
- R5: A captured ratio code below 8 is treated as 8, and one above 21 is treated as 21.
- R6: A strobe while a slot holds a word makes the matching `*_out_valid` high for exactly the following cycle. Otherwise `*_out_valid` is low. The two directions are independent.
- R7: The word delivered is the one held in the slot at the strobe. Each data output keeps its value until the next delivery or resync. A word that arrives on a strobe cycle is captured for the next strobe.
- R8: A valid word that arrives while the slot is occupied, outside a strobe cycle, is dropped and sets that direction's overflow flag. The flag stays set until resync or reset.
- R9: Reset, or a cycle with `resync` high, empties both slots, clears both overflow flags, clears the out-valid outputs and zeroes the data outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync | input | 1 | Resynchronisation: loads config, restarts phase at coincidence |
| ratio_k | input | 5 | Ratio code k, ratio = k/4 |
| lead_sel | input | 2 | Requested strobe lead in fast cycles |
| fast_valid | input | 1 | Fast side offers a word for the slow side |
| fast_data | input | 16 | Word for the slow side |
| slow_valid | input | 1 | Slow side offers a word for the fast side |
| slow_data | input | 16 | Word for the fast side |
| aligned | output | 1 | Predicted-coincidence strobe |
| slow_edge | output | 1 | Slow clock rose at or just before this fast cycle |
| to_slow_valid | output | 1 | Word delivered toward the slow side |
| to_slow_data | output | 16 | Data toward the slow side |
| to_fast_valid | output | 1 | Word delivered toward the fast side |
| to_fast_data | output | 16 | Data toward the fast side |
| to_slow_ovf | output | 1 | Sticky overflow, fast-to-slow slot |
| to_fast_ovf | output | 1 | Sticky overflow, slow-to-fast slot |

## Verification
The bound checker watches several local rules on every cycle. The strobe never fires on two cycles in a row. A delivery is always preceded by a strobe. An overflow flag rises only after a valid word that arrived outside a strobe cycle, and it then stays set. Resync empties the outputs, and data holds steady between deliveries. Other behaviour needs the bench's scenarios and its closed-form reference: the exact strobe and slow-edge positions for each ratio, including the clamping of the lead and the ratio. The same applies to which word is delivered when traffic and strobes collide, and to ignoring configuration changes while running.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
   // slow phase advances by this many quarter-units per fast cycle (ratio = k/STEP)
   localparam int STEP = 4;
   // direction indices for the per-direction slot array
   localparam int DIR_TO_SLOW = 0;
   localparam int DIR_TO_FAST = 1;
   localparam int NUM_DIR     = 2;
endpackage

// File: rtl/rxc_cfg_latch.sv
module rxc_cfg_latch
   import rxc_pkg::*;
#(
   parameter int K_W    = 5,
   parameter int K_MIN  = 8,
   parameter int K_MAX  = 21,
   parameter int LEAD_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              resync,
   input  logic [K_W-1:0]    ratio_k,
   input  logic [LEAD_W-1:0] lead_sel,
   output logic [K_W-1:0]    cfg_k,
   output logic [LEAD_W-1:0] cfg_lead
);
   localparam logic [K_W-1:0] KLO = K_W'(K_MIN);
   localparam logic [K_W-1:0] KHI = K_W'(K_MAX);

   // coincidence period in fast cycles: k / gcd(k, 4)
   function automatic logic [K_W-1:0] period_of(input logic [K_W-1:0] k);
      if (k[1:0] == 2'b00)  return k >> 2;
      else if (!k[0])       return k >> 1;
      else                  return k;
   endfunction

   logic [K_W-1:0]    k_c;
   logic [K_W-1:0]    p_c;
   logic [K_W-1:0]    lead_ext;
   logic [LEAD_W-1:0] lead_c;

   always_comb begin
      if (ratio_k < KLO)      k_c = KLO;
      else if (ratio_k > KHI) k_c = KHI;
      else                    k_c = ratio_k;
      p_c      = period_of(k_c);
      lead_ext = K_W'(lead_sel);
      if (lead_ext >= p_c) lead_c = LEAD_W'(p_c - K_W'(1));
      else                 lead_c = lead_sel;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_k    <= KLO;
         cfg_lead <= '0;
      end else if (resync) begin
         cfg_k    <= k_c;
         cfg_lead <= lead_c;
      end
   end
endmodule

// File: rtl/rxc_phase_acc.sv
module rxc_phase_acc
   import rxc_pkg::*;
#(
   parameter int K_W = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           resync,
   input  logic [K_W-1:0] cfg_k,
   output logic [K_W-1:0] phase,
   output logic           slow_edge
);
   logic [K_W:0]   sum;
   logic [K_W:0]   k_x;
   logic [K_W-1:0] phase_nxt;

   always_comb begin
      k_x = {1'b0, cfg_k};
      sum = {1'b0, phase} + (K_W+1)'(STEP);
      if (sum >= k_x) phase_nxt = K_W'(sum - k_x);
      else            phase_nxt = K_W'(sum);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase <= '0;
      else if (resync) phase <= '0;
      else             phase <= phase_nxt;
   end

   // a residue below STEP means the last increment wrapped (or we sit at the start point)
   assign slow_edge = !resync && (phase < K_W'(STEP));
endmodule

// File: rtl/rxc_align_pred.sv
module rxc_align_pred
   import rxc_pkg::*;
#(
   parameter int K_W    = 5,
   parameter int LEAD_W = 2
) (
   input  logic              resync,
   input  logic [K_W-1:0]    cfg_k,
   input  logic [LEAD_W-1:0] cfg_lead,
   input  logic [K_W-1:0]    phase,
   output logic              aligned
);
   logic [K_W:0]   adv;
   logic [K_W:0]   adv_mod;
   logic [K_W:0]   k_x;
   logic [K_W-1:0] target;

   // strobe when phase + STEP*lead == 0 (mod k), i.e. phase == -STEP*lead mod k
   always_comb begin
      k_x = {1'b0, cfg_k};
      adv = (K_W+1)'(cfg_lead) * (K_W+1)'(STEP);
      if (adv >= k_x) adv_mod = adv - k_x;
      else            adv_mod = adv;
      if (adv_mod == '0) target = '0;
      else               target = K_W'(k_x - adv_mod);
   end

   assign aligned = !resync && (phase == target);
endmodule

// File: rtl/rxc_xfer_slot.sv
module rxc_xfer_slot #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              resync,
   input  logic              strobe,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              ovf
);
   logic              pend;
   logic [DATA_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         hold      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         ovf       <= 1'b0;
      end else if (resync) begin
         pend      <= 1'b0;
         hold      <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         ovf       <= 1'b0;
      end else begin
         out_valid <= strobe && pend;
         if (strobe && pend) out_data <= hold;
         if (in_valid) begin
            if (pend && !strobe) begin
               ovf <= 1'b1;
            end else begin
               hold <= in_data;
               pend <= 1'b1;
            end
         end else if (strobe) begin
            pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ratio_xing_ctrl.sv
module ratio_xing_ctrl
   import rxc_pkg::*;
#(
   parameter int K_W    = 5,
   parameter int K_MIN  = 8,
   parameter int K_MAX  = 21,
   parameter int LEAD_W = 2,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              resync,
   input  logic [K_W-1:0]    ratio_k,
   input  logic [LEAD_W-1:0] lead_sel,
   input  logic              fast_valid,
   input  logic [DATA_W-1:0] fast_data,
   input  logic              slow_valid,
   input  logic [DATA_W-1:0] slow_data,
   output logic              aligned,
   output logic              slow_edge,
   output logic              to_slow_valid,
   output logic [DATA_W-1:0] to_slow_data,
   output logic              to_fast_valid,
   output logic [DATA_W-1:0] to_fast_data,
   output logic              to_slow_ovf,
   output logic              to_fast_ovf
);
   localparam int LEAD_MAX = (1 << LEAD_W) - 1;

   // elaboration-time parameter checks
   if (K_MAX >= (1 << K_W)) begin : g_bad_kmax
      $error("K_MAX does not fit in K_W bits");
   end
   if (K_MIN <= STEP || K_MIN > K_MAX) begin : g_bad_kmin
      $error("K_MIN must exceed STEP and not exceed K_MAX");
   end
   if (STEP * LEAD_MAX >= 2 * K_MIN) begin : g_bad_lead
      $error("lead range too wide for single-subtract modulo");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [K_W-1:0]    cfg_k;
   logic [LEAD_W-1:0] cfg_lead;
   logic [K_W-1:0]    phase;

   rxc_cfg_latch #(.K_W(K_W), .K_MIN(K_MIN), .K_MAX(K_MAX), .LEAD_W(LEAD_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .resync(resync),
      .ratio_k(ratio_k), .lead_sel(lead_sel),
      .cfg_k(cfg_k), .cfg_lead(cfg_lead)
   );

   rxc_phase_acc #(.K_W(K_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .resync(resync),
      .cfg_k(cfg_k), .phase(phase), .slow_edge(slow_edge)
   );

   rxc_align_pred #(.K_W(K_W), .LEAD_W(LEAD_W)) u_pred (
      .resync(resync), .cfg_k(cfg_k), .cfg_lead(cfg_lead),
      .phase(phase), .aligned(aligned)
   );

   logic [NUM_DIR-1:0]             in_v;
   logic [NUM_DIR-1:0][DATA_W-1:0] in_d;
   logic [NUM_DIR-1:0]             out_v;
   logic [NUM_DIR-1:0][DATA_W-1:0] out_d;
   logic [NUM_DIR-1:0]             ovf_v;

   assign in_v[DIR_TO_SLOW] = fast_valid;
   assign in_d[DIR_TO_SLOW] = fast_data;
   assign in_v[DIR_TO_FAST] = slow_valid;
   assign in_d[DIR_TO_FAST] = slow_data;

   for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
      rxc_xfer_slot #(.DATA_W(DATA_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .resync(resync), .strobe(aligned),
         .in_valid(in_v[g]), .in_data(in_d[g]),
         .out_valid(out_v[g]), .out_data(out_d[g]), .ovf(ovf_v[g])
      );
   end

   assign to_slow_valid = out_v[DIR_TO_SLOW];
   assign to_slow_data  = out_d[DIR_TO_SLOW];
   assign to_slow_ovf   = ovf_v[DIR_TO_SLOW];
   assign to_fast_valid = out_v[DIR_TO_FAST];
   assign to_fast_data  = out_d[DIR_TO_FAST];
   assign to_fast_ovf   = ovf_v[DIR_TO_FAST];
endmodule

// File: rtl/rxc_chk.sv
module rxc_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              resync,
   input logic              fast_valid,
   input logic              slow_valid,
   input logic              aligned,
   input logic              to_slow_valid,
   input logic [DATA_W-1:0] to_slow_data,
   input logic              to_fast_valid,
   input logic [DATA_W-1:0] to_fast_data,
   input logic              to_slow_ovf,
   input logic              to_fast_ovf
);
   // R3
   strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n || resync)
      aligned |=> !aligned);

   // R6
   slow_dlv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || resync)
      to_slow_valid |-> $past(aligned));

   // R6
   fast_dlv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || resync)
      to_fast_valid |-> $past(aligned));

   // R8
   slow_ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || resync)
      $rose(to_slow_ovf) |-> ($past(fast_valid) && !$past(aligned)));

   // R8
   fast_ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || resync)
      $rose(to_fast_ovf) |-> ($past(slow_valid) && !$past(aligned)));

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || resync)
      (to_slow_ovf || to_fast_ovf) |=> ($past(to_slow_ovf) <= to_slow_ovf) && ($past(to_fast_ovf) <= to_fast_ovf));

   // R9
   resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(resync) |-> (!to_slow_valid && !to_fast_valid && !to_slow_ovf && !to_fast_ovf
                         && to_slow_data == '0 && to_fast_data == '0));

   // R7
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || resync)
      (!$past(resync) && !to_slow_valid && !to_fast_valid) |-> ($stable(to_slow_data) && $stable(to_fast_data)));
endmodule

bind ratio_xing_ctrl rxc_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .resync(resync),
   .fast_valid(fast_valid), .slow_valid(slow_valid), .aligned(aligned),
   .to_slow_valid(to_slow_valid), .to_slow_data(to_slow_data),
   .to_fast_valid(to_fast_valid), .to_fast_data(to_fast_data),
   .to_slow_ovf(to_slow_ovf), .to_fast_ovf(to_fast_ovf)
);

// File: tb/ratio_xing_ctrl_bench.sv
module ratio_xing_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        resync = 1'b1;
   logic [4:0]  ratio_k = 5'd8;
   logic [1:0]  lead_sel = 2'd0;
   logic        fast_valid = 1'b0;
   logic [15:0] fast_data = '0;
   logic        slow_valid = 1'b0;
   logic [15:0] slow_data = '0;
   logic        aligned, slow_edge;
   logic        to_slow_valid, to_fast_valid, to_slow_ovf, to_fast_ovf;
   logic [15:0] to_slow_data, to_fast_data;

   always #4 clk = ~clk;

   ratio_xing_ctrl u_ratio_xing_ctrl (
      .clk(clk), .rst_n(rst_n), .resync(resync), .ratio_k(ratio_k), .lead_sel(lead_sel),
      .fast_valid(fast_valid), .fast_data(fast_data), .slow_valid(slow_valid), .slow_data(slow_data),
      .aligned(aligned), .slow_edge(slow_edge),
      .to_slow_valid(to_slow_valid), .to_slow_data(to_slow_data),
      .to_fast_valid(to_fast_valid), .to_fast_data(to_fast_data),
      .to_slow_ovf(to_slow_ovf), .to_fast_ovf(to_fast_ovf)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   int          m_n, m_k, m_l;
   bit          m_pend[2], m_ovf[2], m_outv[2];
   logic [15:0] m_hold[2], m_outd[2];
   bit          was_resync;
   string       cfg_tag;

   function automatic int per(int k);
      if (k % 4 == 0) return k / 4;
      if (k % 2 == 0) return k / 2;
      return k;
   endfunction

   function automatic int clampk(int k);
      if (k < 8)  return 8;
      if (k > 21) return 21;
      return k;
   endfunction

   function automatic bit exp_aligned();
      return !resync && (((m_n + m_l) % per(m_k)) == 0);
   endfunction

   function automatic bit exp_slow_edge();
      return !resync && (((4 * m_n) % m_k) < 4);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int d = 0; d < 2; d++) begin
         m_pend[d] = 0; m_ovf[d] = 0; m_outv[d] = 0; m_hold[d] = '0; m_outd[d] = '0;
      end
      m_n = 0;
   endtask

   task automatic model_update();
      bit          al;
      bit          vin[2];
      logic [15:0] din[2];
      was_resync = !rst_n || resync;
      if (!rst_n) begin
         m_k = 8; m_l = 0; clear_model();
      end else if (resync) begin
         m_k = clampk(int'(ratio_k));
         m_l = (int'(lead_sel) >= per(m_k)) ? per(m_k) - 1 : int'(lead_sel);
         clear_model();
      end else begin
         al = exp_aligned();
         vin[0] = fast_valid; din[0] = fast_data;
         vin[1] = slow_valid; din[1] = slow_data;
         for (int d = 0; d < 2; d++) begin
            m_outv[d] = al && m_pend[d];
            if (al && m_pend[d]) m_outd[d] = m_hold[d];
            if (vin[d]) begin
               if (m_pend[d] && !al) m_ovf[d] = 1;
               else begin m_hold[d] = din[d]; m_pend[d] = 1; end
            end else if (al) m_pend[d] = 0;
         end
         m_n++;
      end
   endtask

   task automatic check_all();
      string t_al, t_v, t_o;
      t_al = cfg_tag;
      if (!resync && (int'(ratio_k) != m_k || int'(lead_sel) != m_l)) t_al = {cfg_tag, "/R1"};
      t_v = was_resync ? "R9" : "R6";
      t_o = was_resync ? "R9" : "R8";
      chk(aligned == exp_aligned(), t_al, aligned, exp_aligned());
      chk(slow_edge == exp_slow_edge(), "R2", slow_edge, exp_slow_edge());
      chk(to_slow_valid == m_outv[0], t_v, to_slow_valid, m_outv[0]);
      chk(to_fast_valid == m_outv[1], t_v, to_fast_valid, m_outv[1]);
      chk(to_slow_data == m_outd[0], was_resync ? "R9" : "R7", to_slow_data, m_outd[0]);
      chk(to_fast_data == m_outd[1], was_resync ? "R9" : "R7", to_fast_data, m_outd[1]);
      chk(to_slow_ovf == m_ovf[0], t_o, to_slow_ovf, m_ovf[0]);
      chk(to_fast_ovf == m_ovf[1], t_o, to_fast_ovf, m_ovf[1]);
   endtask

   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
      model_update();
      check_all();
   endtask

   task automatic run_cfg(input int k, input int ld, input int pct, input int len);
      int kc, p;
      kc = clampk(k);
      p  = per(kc);
      if (kc != k)       cfg_tag = "R5";
      else if (ld >= p)  cfg_tag = "R4";
      else               cfg_tag = "R3";
      resync = 1; ratio_k = 5'(k); lead_sel = 2'(ld);
      fast_valid = 0; slow_valid = 0;
      cycle();
      cycle();
      resync = 0;
      for (int i = 0; i < len; i++) begin
         // R1: disturb configuration ports while running
         if ($urandom % 8 == 0) begin
            ratio_k  = 5'($urandom);
            lead_sel = 2'($urandom);
         end
         fast_valid = ($urandom % 100) < pct;
         fast_data  = 16'($urandom);
         slow_valid = ($urandom % 100) < (100 - pct);
         slow_data  = 16'($urandom);
         cycle();
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      m_k = 8; m_l = 0; clear_model(); was_resync = 1; cfg_tag = "R3";
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state (R9)
      chk(!aligned && !slow_edge, "R9", {aligned, slow_edge}, 0);
      chk(!to_slow_valid && !to_fast_valid && !to_slow_ovf && !to_fast_ovf, "R9",
          {to_slow_valid, to_fast_valid, to_slow_ovf, to_fast_ovf}, 0);
      rst_n = 1;
      // directed corners: smallest/largest ratios, lead clamps, out-of-range codes
      run_cfg(8, 3, 30, 60);
      run_cfg(8, 0, 50, 60);
      run_cfg(9, 2, 40, 120);
      run_cfg(12, 3, 20, 90);
      run_cfg(21, 3, 70, 200);
      run_cfg(10, 1, 10, 120);
      run_cfg(5, 0, 50, 80);
      run_cfg(30, 2, 50, 200);
      run_cfg(13, 0, 90, 150);
      run_cfg(16, 3, 60, 80);
      run_cfg(14, 3, 35, 150);
      for (int r = 0; r < 14; r++)
         run_cfg(int'($urandom % 32), int'($urandom % 4), int'($urandom % 101), 250);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule